// File: doc/BRIEF.md
# Per-Channel Raster Line State Tracker

This block runs once per scanline and walks four raster channels, one after the other. For each channel it decides what the next line will be. The line can repeat the previous data, start a new data line, begin a fresh control block, or be idle. The block keeps the repeat count, the line count and the data address for that channel. When the current control block runs out, it follows the link to the next block. It reads every control block through a simple request/acknowledge memory port.

The line state of all four channels lives in one 16-bit word, four bits per channel. The word is rotated right by one nibble before each channel is handled, so the channel being worked on is always in the low nibble. In each nibble, the low three bits select the action. The top bit asks for a completion status to be written back for the block that was just finished.

For each channel the block emits one record: the channel, its new state, a two-bit line control field and the data address. A controller that loads line buffers uses these records.

Top module: `scan_chain_walker`

## Requirements
- R1: After reset, `lane_states` is 0 (every channel in FirstTime with no flag), `busy` is 0, and `out_valid` and `mem_req` are 0.
- R2: A `line_start` seen while idle starts one pass. The pass emits exactly four `out_valid` pulses with `out_ch` 0, 1, 2, 3 in that order, none back to back, and then `busy` returns to 0. A `line_start` seen while busy is ignored.
- R3: State codes are FirstTime=0, NewRCB=1, NewLine=2, RepeatingLine=3 and InactiveChannel=4, held in bits [2:0] of a nibble, with bit 3 as the write-back flag. At rest, channel 0's nibble is at [7:4], channel 1's at [11:8], channel 2's at [15:12] and channel 3's at [3:0].
- R4: In an active state with a non-negative repeat count, the channel becomes RepeatingLine. The repeat count drops by one and the data address is unchanged.
- R5: In an active state with a negative repeat count and a non-negative line count, the channel becomes NewLine. The repeat count is reloaded from the block's reload value, the line count drops by one and the address advances by words-per-line.
- R6: When both counts are negative, the flag is set and the next-block pointer is followed. A null pointer gives InactiveChannel, address 0 and control 0. An inactive channel stays inactive.
- R7: The word at block offset 0 must equal `SEAL_WORD`. On a mismatch, `bad_seal` pulses with `bad_ch` in the same cycle as the channel's record, and the channel becomes inactive with address 0.
- R8: A block holds, at offsets 1 to 5, the line count, the repeat reload (also the starting repeat count), words-per-line, the first data address and the next-block pointer. A good block gives NewRCB with the loaded address.
- R9: A channel whose flag is set first writes `16'h0001` to the finished block's base + 6, then clears the flag, before anything else is done for that channel.
- R10: A FirstTime channel reads its first block pointer at `HEAD_BASE` + channel. A null pointer makes it inactive without setting the flag.
- R11: `out_ctl` bit 0 (want word transfer) is 1 for NewRCB, NewLine and RepeatingLine. Bit 1 (don't swap buffers) is 1 only for RepeatingLine.
- R12: Once `mem_req` is raised, it stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Scanline start pulse |
| busy | output | 1 | Pass in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 16 | Read data |
| out_valid | output | 1 | Channel record valid |
| out_ch | output | 2 | Channel of the record |
| out_state | output | 3 | New line state |
| out_ctl | output | 2 | {don't swap, want transfer} |
| out_addr | output | 16 | Data address for the line |
| bad_seal | output | 1 | Bad seal pulse |
| bad_ch | output | 2 | Channel with bad seal |
| lane_states | output | 16 | Packed state word |

## Verification
The bench tries four kinds of chain.
- A short hand-built chain with fixed counts separates repeat lines, new lines and block hand-over.
- A chain ending in a corrupted block shows that a seal failure is told apart from a clean chain end.
- A null head pointer checks the idle channel.
- A looping chain with random counts, including counts of -1, exercises every change of the counters over forty passes.

Along the way, the bench checks every write-back address, the packed state word after each pass, and that start pulses arriving during a pass are dropped.

// File: rtl/scw_pkg.sv
package scw_pkg;
    localparam int W          = 16;
    localparam int NCH        = 4;
    localparam int NIB        = 4;
    localparam int WORD_W     = NCH * NIB;
    localparam int CH_W       = $clog2(NCH);
    localparam int STATUS_OFS = 6;
    localparam logic [W-1:0] DONE_CODE = 16'h0001;

    localparam logic [1:0] CTL_WANT   = 2'b01;
    localparam logic [1:0] CTL_NOSWAP = 2'b10;

    typedef enum logic [2:0] {
        ST_FIRST   = 3'd0,
        ST_NEWBLK  = 3'd1,
        ST_NEWLINE = 3'd2,
        ST_REPEAT  = 3'd3,
        ST_INACT   = 3'd4
    } lstate_e;

    typedef enum logic [1:0] {STEP_REPEAT, STEP_NEWLINE, STEP_END} step_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ROT, S_CHK, S_STWR, S_DEC, S_HEAD, S_LOAD, S_EMIT
    } fsm_e;

    typedef struct packed {
        logic [W-1:0] base;
        logic [W-1:0] stat;
        logic [W-1:0] nxt;
        logic [W-1:0] wpl;
        logic [W-1:0] addr;
        logic [W-1:0] lines;
        logic [W-1:0] reload;
        logic [W-1:0] rep;
    } chan_t;

    function automatic logic [WORD_W-1:0] rotr_nib(input logic [WORD_W-1:0] w);
        return {w[NIB-1:0], w[WORD_W-1:NIB]};
    endfunction
endpackage

// File: rtl/scw_lane_word.sv
module scw_lane_word
    import scw_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  lstate_e           put_state,
    output logic [WORD_W-1:0] rot_o,
    output lstate_e           low_state,
    output logic              low_flag,
    output logic [WORD_W-1:0] put_o,
    output logic [WORD_W-1:0] flag_set_o,
    output logic [WORD_W-1:0] flag_clr_o
);
    always_comb begin
        rot_o      = rotr_nib(word_i);
        low_state  = lstate_e'(word_i[2:0]);
        low_flag   = word_i[NIB-1];
        put_o      = {word_i[WORD_W-1:3], put_state};
        flag_set_o = word_i;
        flag_set_o[NIB-1] = 1'b1;
        flag_clr_o = word_i;
        flag_clr_o[NIB-1] = 1'b0;
    end
endmodule

// File: rtl/scw_line_step.sv
module scw_line_step
    import scw_pkg::*;
(
    input  chan_t cur_i,
    output step_e kind_o,
    output chan_t next_o
);
    always_comb begin
        next_o = cur_i;
        if (!cur_i.rep[W-1]) begin
            kind_o     = STEP_REPEAT;
            next_o.rep = cur_i.rep - 1'b1;
        end else if (!cur_i.lines[W-1]) begin
            kind_o       = STEP_NEWLINE;
            next_o.rep   = cur_i.reload;
            next_o.lines = cur_i.lines - 1'b1;
            next_o.addr  = cur_i.addr + cur_i.wpl;
        end else begin
            kind_o = STEP_END;
        end
    end
endmodule

// File: rtl/scan_chain_walker.sv
module scan_chain_walker
    import scw_pkg::*;
#(
    parameter logic [15:0] HEAD_BASE = 16'h0010,
    parameter logic [15:0] SEAL_WORD = 16'h5EA1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic              mem_ack,
    input  logic [W-1:0]      mem_rdata,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_ch,
    output logic [2:0]        out_state,
    output logic [1:0]        out_ctl,
    output logic [W-1:0]      out_addr,
    output logic              bad_seal,
    output logic [CH_W-1:0]   bad_ch,
    output logic [WORD_W-1:0] lane_states
);
    fsm_e              st;
    logic [WORD_W-1:0] word;
    logic [CH_W-1:0]   cur;
    logic [2:0]        lidx;
    lstate_e           em_state;
    logic [1:0]        em_ctl;
    logic              bad;
    chan_t             chans [NCH];

    logic [WORD_W-1:0] w_rot, w_put, w_fset, w_fclr;
    lstate_e           low_state;
    logic              low_flag;
    step_e             kind;
    chan_t             step_next;

    scw_lane_word u_word (
        .word_i(word), .put_state(em_state), .rot_o(w_rot), .low_state(low_state),
        .low_flag(low_flag), .put_o(w_put), .flag_set_o(w_fset), .flag_clr_o(w_fclr)
    );

    scw_line_step u_step (.cur_i(chans[cur]), .kind_o(kind), .next_o(step_next));

    always_comb begin
        mem_req   = (st == S_STWR) || (st == S_HEAD) || (st == S_LOAD);
        mem_we    = (st == S_STWR);
        mem_wdata = DONE_CODE;
        case (st)
            S_STWR:  mem_addr = chans[cur].stat + W'(STATUS_OFS);
            S_HEAD:  mem_addr = HEAD_BASE + {{(W-CH_W){1'b0}}, cur};
            S_LOAD:  mem_addr = chans[cur].base + {{(W-3){1'b0}}, lidx};
            default: mem_addr = '0;
        endcase
    end

    assign busy        = (st != S_IDLE);
    assign out_valid   = (st == S_EMIT);
    assign out_ch      = cur;
    assign out_state   = em_state;
    assign out_ctl     = em_ctl;
    assign out_addr    = chans[cur].addr;
    assign bad_seal    = bad;
    assign bad_ch      = cur;
    assign lane_states = word;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            word     <= '0;
            cur      <= '0;
            lidx     <= '0;
            em_state <= ST_FIRST;
            em_ctl   <= '0;
            bad      <= 1'b0;
            for (int i = 0; i < NCH; i++) chans[i] <= '0;
        end else begin
            bad <= 1'b0;
            case (st)
                S_IDLE: if (line_start) begin
                    st  <= S_ROT;
                    cur <= '0;
                end
                S_ROT: begin
                    word <= w_rot;
                    st   <= S_CHK;
                end
                S_CHK: st <= low_flag ? S_STWR : S_DEC;
                S_STWR: if (mem_ack) begin
                    word <= w_fclr;
                    st   <= S_DEC;
                end
                S_DEC: begin
                    case (low_state)
                        ST_FIRST: st <= S_HEAD;
                        ST_NEWBLK, ST_NEWLINE, ST_REPEAT: begin
                            case (kind)
                                STEP_REPEAT: begin
                                    chans[cur] <= step_next;
                                    em_state   <= ST_REPEAT;
                                    em_ctl     <= CTL_WANT | CTL_NOSWAP;
                                    st         <= S_EMIT;
                                end
                                STEP_NEWLINE: begin
                                    chans[cur] <= step_next;
                                    em_state   <= ST_NEWLINE;
                                    em_ctl     <= CTL_WANT;
                                    st         <= S_EMIT;
                                end
                                default: begin
                                    word            <= w_fset;
                                    chans[cur].stat <= chans[cur].base;
                                    if (chans[cur].nxt == '0) begin
                                        chans[cur].addr <= '0;
                                        em_state        <= ST_INACT;
                                        em_ctl          <= '0;
                                        st              <= S_EMIT;
                                    end else begin
                                        chans[cur].base <= chans[cur].nxt;
                                        lidx            <= '0;
                                        st              <= S_LOAD;
                                    end
                                end
                            endcase
                        end
                        default: begin
                            em_state <= ST_INACT;
                            em_ctl   <= '0;
                            st       <= S_EMIT;
                        end
                    endcase
                end
                S_HEAD: if (mem_ack) begin
                    if (mem_rdata == '0) begin
                        chans[cur].addr <= '0;
                        em_state        <= ST_INACT;
                        em_ctl          <= '0;
                        st              <= S_EMIT;
                    end else begin
                        chans[cur].base <= mem_rdata;
                        lidx            <= '0;
                        st              <= S_LOAD;
                    end
                end
                S_LOAD: if (mem_ack) begin
                    lidx <= lidx + 1'b1;
                    case (lidx)
                        3'd0: if (mem_rdata != SEAL_WORD) begin
                            bad             <= 1'b1;
                            chans[cur].addr <= '0;
                            em_state        <= ST_INACT;
                            em_ctl          <= '0;
                            st              <= S_EMIT;
                        end
                        3'd1: chans[cur].lines <= mem_rdata;
                        3'd2: begin
                            chans[cur].reload <= mem_rdata;
                            chans[cur].rep    <= mem_rdata;
                        end
                        3'd3: chans[cur].wpl  <= mem_rdata;
                        3'd4: chans[cur].addr <= mem_rdata;
                        default: begin
                            chans[cur].nxt <= mem_rdata;
                            em_state       <= ST_NEWBLK;
                            em_ctl         <= CTL_WANT;
                            st             <= S_EMIT;
                        end
                    endcase
                end
                S_EMIT: begin
                    word <= w_put;
                    if (cur == CH_W'(NCH - 1)) st <= S_IDLE;
                    else begin
                        cur <= cur + 1'b1;
                        st  <= S_ROT;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/scw_chk.sv
module scw_chk
    import scw_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         line_start,
    input logic         busy,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic         mem_ack,
    input logic         out_valid,
    input logic [2:0]   out_state,
    input logic [1:0]   out_ctl,
    input logic [W-1:0] out_addr,
    input logic         bad_seal
);
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R11
    rep_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_state == 3'd3 |-> out_ctl == 2'b11);

    // R6
    inact_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_state == 3'd4 |-> out_addr == '0 && out_ctl == 2'b00);

    // R2
    emit_gap_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(line_start));

    // R7
    bad_emit_chk: assert property (@(posedge clk) disable iff (rst)
        bad_seal |-> out_valid && out_state == 3'd4);
endmodule

bind scan_chain_walker scw_chk u_chk (
    .clk(clk), .rst(rst), .line_start(line_start), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .out_valid(out_valid), .out_state(out_state), .out_ctl(out_ctl),
    .out_addr(out_addr), .bad_seal(bad_seal)
);

// File: tb/scan_chain_walker_tb.sv
module scan_chain_walker_tb;
    localparam logic [15:0] HB   = 16'h0010;
    localparam logic [15:0] SEAL = 16'h5EA1;

    logic clk = 1'b0, rst = 1'b1, line_start = 1'b0;
    logic busy, mem_req, mem_we, mem_ack, out_valid, bad_seal;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, out_addr, lane_states;
    logic [1:0] out_ch, out_ctl, bad_ch;
    logic [2:0] out_state;

    scan_chain_walker #(.HEAD_BASE(HB), .SEAL_WORD(SEAL)) u_dut (
        .clk(clk), .rst(rst), .line_start(line_start), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ch(out_ch),
        .out_state(out_state), .out_ctl(out_ctl), .out_addr(out_addr),
        .bad_seal(bad_seal), .bad_ch(bad_ch), .lane_states(lane_states)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model
    logic [15:0] mem [0:255];
    int wr_cnt;
    logic [15:0] wr_last;
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wr_cnt  <= 0;
            wr_last <= '0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[7:0]] = mem_wdata;
                    wr_cnt  <= wr_cnt + 1;
                    wr_last <= mem_addr;
                end else mem_rdata <= mem[mem_addr[7:0]];
            end
        end
    end

    // reference model
    logic [2:0]  m_st [4];
    logic        m_fl [4];
    logic [15:0] m_base [4], m_stat [4], m_nxt [4], m_lines [4];
    logic [15:0] m_rel [4], m_rep [4], m_wpl [4], m_addr [4];
    logic [2:0]  e_st;
    logic [1:0]  e_ctl;
    logic        e_bad, e_wr;
    logic [15:0] e_wa;
    string       e_tag;

    task automatic go_inact(input int ch);
        m_addr[ch] = '0; e_st = 3'd4; e_ctl = 2'b00;
    endtask

    task automatic mload(input int ch, input logic [15:0] p);
        m_base[ch] = p;
        if (mem[p[7:0]] != SEAL) begin
            e_bad = 1'b1; go_inact(ch); e_tag = "R7";
        end else begin
            m_lines[ch] = mem[p[7:0] + 8'd1];
            m_rel[ch]   = mem[p[7:0] + 8'd2];
            m_rep[ch]   = m_rel[ch];
            m_wpl[ch]   = mem[p[7:0] + 8'd3];
            m_addr[ch]  = mem[p[7:0] + 8'd4];
            m_nxt[ch]   = mem[p[7:0] + 8'd5];
            e_st = 3'd1; e_ctl = 2'b01;
            if (e_tag == "") e_tag = "R8";
        end
    endtask

    task automatic mstep(input int ch);
        logic [15:0] p;
        e_wr = 1'b0; e_wa = '0; e_bad = 1'b0; e_tag = "";
        if (m_fl[ch]) begin
            e_wr = 1'b1; e_wa = m_stat[ch] + 16'd6; m_fl[ch] = 1'b0;
        end
        case (m_st[ch])
            3'd0: begin
                e_tag = "R10";
                p = mem[16 + ch];
                if (p == 16'h0) go_inact(ch);
                else mload(ch, p);
            end
            3'd1, 3'd2, 3'd3: begin
                if (!m_rep[ch][15]) begin
                    m_rep[ch] = m_rep[ch] - 16'd1;
                    e_st = 3'd3; e_ctl = 2'b11; e_tag = "R4";
                end else if (!m_lines[ch][15]) begin
                    m_rep[ch]   = m_rel[ch];
                    m_lines[ch] = m_lines[ch] - 16'd1;
                    m_addr[ch]  = m_addr[ch] + m_wpl[ch];
                    e_st = 3'd2; e_ctl = 2'b01; e_tag = "R5";
                end else begin
                    m_fl[ch] = 1'b1;
                    m_stat[ch] = m_base[ch];
                    if (m_nxt[ch] == 16'h0) begin
                        go_inact(ch); e_tag = "R6";
                    end else mload(ch, m_nxt[ch]);
                end
            end
            default: begin go_inact(ch); e_tag = "R6"; end
        endcase
        m_st[ch] = e_st;
    endtask

    int exp_ch = 0, emits = 0, wr_prev = 0, r12_viol = 0;
    logic prev_req = 1'b0, prev_ack = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_req && !prev_ack && !mem_req) r12_viol++;
            prev_req = mem_req; prev_ack = mem_ack;
            if (out_valid) begin
                mstep(exp_ch);
                chk(out_ch == 2'(exp_ch), "R2 channel order", 32'(out_ch), exp_ch);
                chk(out_state == e_st, {e_tag, " state"}, 32'(out_state), 32'(e_st));
                chk(out_ctl == e_ctl, "R11 control", 32'(out_ctl), 32'(e_ctl));
                chk(out_addr == m_addr[exp_ch], {e_tag, " address"}, 32'(out_addr), 32'(m_addr[exp_ch]));
                chk(bad_seal == e_bad && (!e_bad || bad_ch == 2'(exp_ch)), "R7 bad seal",
                    {bad_ch, bad_seal}, {2'(exp_ch), e_bad});
                chk((wr_cnt - wr_prev) == (e_wr ? 1 : 0), "R9 write count", wr_cnt - wr_prev, e_wr);
                if (e_wr) chk(wr_last == e_wa && mem[e_wa[7:0]] == 16'h0001, "R9 write address",
                              32'(wr_last), 32'(e_wa));
                wr_prev = wr_cnt;
                exp_ch = (exp_ch + 1) % 4;
                emits++;
            end
        end
    end

    task automatic put_blk(input logic [7:0] p, input logic [15:0] seal, input logic [15:0] lines,
                           input logic [15:0] rel, input logic [15:0] wpl, input logic [15:0] a,
                           input logic [15:0] nxt);
        mem[p] = seal; mem[p+1] = lines; mem[p+2] = rel;
        mem[p+3] = wpl; mem[p+4] = a; mem[p+5] = nxt;
    endtask

    function automatic logic [15:0] exp_word();
        logic [3:0] n [4];
        for (int c = 0; c < 4; c++) n[c] = {m_fl[c], m_st[c]};
        return {n[2], n[1], n[0], n[3]};
    endfunction

    initial begin
        int unsigned seed;
        int e0;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        for (int c = 0; c < 4; c++) begin
            m_st[c] = 3'd0; m_fl[c] = 1'b0; m_base[c] = 0; m_stat[c] = 0; m_nxt[c] = 0;
            m_lines[c] = 0; m_rel[c] = 0; m_rep[c] = 0; m_wpl[c] = 0; m_addr[c] = 0;
        end
        mem[16] = 16'h0040; mem[17] = 16'h0050; mem[18] = 16'h0000; mem[19] = 16'h0060;
        put_blk(8'h40, SEAL, 16'd1, 16'd0, 16'h0020, 16'h1000, 16'h0048);
        put_blk(8'h48, SEAL, 16'hFFFF, 16'hFFFF, 16'h0004, 16'h2000, 16'h0000);
        put_blk(8'h50, SEAL, 16'd0, 16'd1, 16'h0010, 16'h3000, 16'h0058);
        put_blk(8'h58, 16'hBAD0, 16'd3, 16'd3, 16'h0001, 16'h4000, 16'h0000);
        for (int k = 0; k < 3; k++)
            put_blk(8'(8'h60 + 8 * k), SEAL, 16'($urandom_range(0, 3)) - 16'd1,
                    16'($urandom_range(0, 2)) - 16'd1, 16'($urandom), 16'($urandom),
                    (k == 2) ? 16'h0060 : 16'(16'h0068 + 8 * k));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(lane_states == 16'h0 && !busy && !out_valid && !mem_req, "R1 reset state",
            {lane_states, busy, out_valid, mem_req}, 0);

        for (int pass = 0; pass < 40; pass++) begin
            e0 = emits;
            line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            if (pass % 2 == 1) begin
                repeat (3) @(negedge clk);
                line_start = 1'b1;
                @(negedge clk);
                line_start = 1'b0;
            end
            do @(negedge clk); while (busy);
            chk(emits - e0 == 4, "R2 records per pass", emits - e0, 4);
            chk(lane_states == exp_word(), "R3 packed word", 32'(lane_states), 32'(exp_word()));
            repeat (4) @(negedge clk);
            chk(!busy && emits - e0 == 4, "R2 start while busy ignored", {busy, 8'(emits - e0)}, 4);
        end
        chk(r12_viol == 0, "R12 request held until ack", r12_viol, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule